// File: doc/BRIEF.md
# Legacy Memory Segment Steering Decoder

This block steers memory accesses that land in a 96 KB legacy window (addresses 0D8000h through 0EFFFFh) either to the DRAM port or to the downstream I/O link. The window is split into six consecutive 16 KB segments. Each segment has a 2-bit attribute in a software-visible 32-bit register. Reads and writes are routed independently, so a segment can be shadowed read-only or write-only: a read and a write to the same address may go to different targets.

Software programs the attribute register through a 32-bit configuration port with per-byte enables. The register contents are always visible on the read-data output. Each access request carries a 20-bit address and a write flag. One clock later the block returns a registered decision: a valid strobe, the chosen target, and a flag that says whether the address hit a decoded segment.

Top module: `shadow_steer`

## Requirements
- R1: After reset the attribute register reads 00000000h, so every in-window access is routed to the I/O link (`rsp_to_dram` = 0).
- R2: Only bits 1:0, 5:4, 9:8, 13:12, 17:16 and 21:20 are storage. All other bits read as zero, and writing ones to them has no effect.
- R3: A configuration write changes only the bytes whose `cfg_be` bit is 1 (`cfg_be[k]` covers bits 8k+7:8k). The other bytes keep their value.
- R4: The segment is chosen from address bits 19:14 alone, and bits 13:0 are ignored. Segment k (k = 0..5) starts at 0D8000h + k*4000h and uses the attribute at bits 4k+1:4k.
- R5: Attribute 00 routes both reads and writes to the I/O link. The target encoding is `rsp_to_dram` = 1 for DRAM and 0 for the I/O link.
- R6: Attribute 01 routes reads to DRAM and writes to the I/O link.
- R7: Attribute 10 routes writes to DRAM and reads to the I/O link.
- R8: Attribute 11 routes both reads and writes to DRAM.
- R9: An address outside the six segments gives `rsp_in_window` = 0 and the target set by parameter `OUTSIDE_TO_DRAM` (default 0, the I/O link). Any address inside the segments gives `rsp_in_window` = 1.
- R10: `rsp_valid` is high exactly in the cycle after a cycle with `req_valid` high. When no request was made, the response fields hold their values.
- R11: The decision uses the register value present on the request cycle. A configuration write in that same cycle affects only later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_be | input | 4 | Byte enables for a configuration write |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Current attribute register value |
| req_valid | input | 1 | Access request valid |
| req_addr | input | 20 | Access address |
| req_is_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Decision valid, one cycle after the request |
| rsp_to_dram | output | 1 | 1 = DRAM, 0 = I/O link |
| rsp_in_window | output | 1 | 1 = address hit one of the six segments |

## Verification
The assertions check on every cycle that:
- the reserved register bits stay zero;
- disabled bytes hold across a write;
- at most one segment comparator fires;
- the valid strobe tracks the request one cycle later;
- out-of-window responses carry the default target.

Only the bench's scenarios can show the following:
- each attribute value steers reads and writes to the correct port;
- each segment maps to the right field;
- the segment boundaries sit where they should;
- a write that coincides with a request does not affect that request.

// File: rtl/shadow_steer_pkg.sv
package shadow_steer_pkg;
  localparam int ATTR_W       = 2;
  localparam int FIELD_STRIDE = 4;

  typedef enum logic {
    TGT_LINK = 1'b0,
    TGT_DRAM = 1'b1
  } target_e;

  typedef struct packed {
    logic    valid;
    target_e target;
    logic    in_window;
  } decision_t;
endpackage

// File: rtl/steer_cfg_reg.sv
module steer_cfg_reg
  import shadow_steer_pkg::*;
#(
  parameter int REG_W   = 32,
  parameter int NUM_SEG = 6
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr,
  input  logic [REG_W/8-1:0] be,
  input  logic [REG_W-1:0]   wdata,
  output logic [REG_W-1:0]   q
);
  localparam int NBYTES = REG_W / 8;

  function automatic logic [REG_W-1:0] make_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      m[i*FIELD_STRIDE +: ATTR_W] = '1;
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] STORE_MASK = make_mask();

  logic [REG_W-1:0] store;

  for (genvar b = 0; b < NBYTES; b++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        store[b*8 +: 8] <= '0;
      end else if (wr && be[b]) begin
        store[b*8 +: 8] <= wdata[b*8 +: 8] & STORE_MASK[b*8 +: 8];
      end
    end

    // R3: a byte whose enable is low keeps its value
    p_byte_hold_r3 : assert property (@(posedge clk) disable iff (rst)
      (wr && !be[b]) |=> $stable(store[b*8 +: 8]));
  end

  assign q = store;

  // R2: bits outside the attribute fields never become one
  p_rsvd_zero_r2 : assert property (@(posedge clk) disable iff (rst)
    (store & ~STORE_MASK) == '0);
endmodule

// File: rtl/steer_seg_lookup.sv
module steer_seg_lookup
  import shadow_steer_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int SEG_SHIFT = 14,
  parameter int NUM_SEG   = 6,
  parameter int BASE_SEG  = 'h36,
  parameter int REG_W     = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  attr_reg,
  output logic [ATTR_W-1:0] attr,
  output logic              hit
);
  localparam int TAG_W = ADDR_W - SEG_SHIFT;

  logic [TAG_W-1:0]     tag;
  logic [NUM_SEG-1:0]   seg_hit;
  logic                 unused_offset;

  assign tag           = addr[ADDR_W-1:SEG_SHIFT];
  assign unused_offset = ^addr[SEG_SHIFT-1:0];

  for (genvar i = 0; i < NUM_SEG; i++) begin : g_cmp
    localparam logic [TAG_W-1:0] SEG_TAG = TAG_W'(BASE_SEG + i);
    assign seg_hit[i] = (tag == SEG_TAG);
  end

  always_comb begin
    attr = '0;
    for (int i = 0; i < NUM_SEG; i++) begin
      if (seg_hit[i]) attr = attr_reg[i*FIELD_STRIDE +: ATTR_W];
    end
  end

  assign hit = |seg_hit;

  // R4: segments never overlap
  p_one_seg_r4 : assert property (@(posedge clk) disable iff (rst)
    $onehot0(seg_hit));
endmodule

// File: rtl/steer_route.sv
module steer_route
  import shadow_steer_pkg::*;
#(
  parameter bit OUTSIDE_TO_DRAM = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_is_write,
  input  logic              hit,
  input  logic [ATTR_W-1:0] attr,
  output decision_t         dec
);
  target_e next_tgt;

  always_comb begin
    if (!hit) begin
      next_tgt = target_e'(OUTSIDE_TO_DRAM);
    end else if (req_is_write) begin
      next_tgt = attr[1] ? TGT_DRAM : TGT_LINK;
    end else begin
      next_tgt = attr[0] ? TGT_DRAM : TGT_LINK;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dec <= '{valid: 1'b0, target: TGT_LINK, in_window: 1'b0};
    end else begin
      dec.valid <= req_valid;
      if (req_valid) begin
        dec.target    <= next_tgt;
        dec.in_window <= hit;
      end
    end
  end

  // R10: the strobe follows the request by one cycle
  p_strobe_r10 : assert property (@(posedge clk) disable iff (rst)
    req_valid |=> dec.valid);
  p_no_strobe_r10 : assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !dec.valid);
  p_hold_r10 : assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(dec.target) && $stable(dec.in_window)));
  // R9: a miss always carries the default target
  p_outside_r9 : assert property (@(posedge clk) disable iff (rst)
    (dec.valid && !dec.in_window) |-> (dec.target == target_e'(OUTSIDE_TO_DRAM)));
endmodule

// File: rtl/shadow_steer.sv
module shadow_steer
  import shadow_steer_pkg::*;
#(
  parameter int ADDR_W          = 20,
  parameter int REG_W           = 32,
  parameter int NUM_SEG         = 6,
  parameter int SEG_SHIFT       = 14,
  parameter int BASE_SEG        = 'h36,
  parameter bit OUTSIDE_TO_DRAM = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr,
  input  logic [REG_W/8-1:0] cfg_be,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               req_valid,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic               req_is_write,
  output logic               rsp_valid,
  output logic               rsp_to_dram,
  output logic               rsp_in_window
);
  logic [REG_W-1:0]  attr_reg;
  logic [ATTR_W-1:0] seg_attr;
  logic              seg_hit;
  decision_t         dec;

  steer_cfg_reg #(
    .REG_W   (REG_W),
    .NUM_SEG (NUM_SEG)
  ) i_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .be    (cfg_be),
    .wdata (cfg_wdata),
    .q     (attr_reg)
  );

  steer_seg_lookup #(
    .ADDR_W    (ADDR_W),
    .SEG_SHIFT (SEG_SHIFT),
    .NUM_SEG   (NUM_SEG),
    .BASE_SEG  (BASE_SEG),
    .REG_W     (REG_W)
  ) i_lookup (
    .clk      (clk),
    .rst      (rst),
    .addr     (req_addr),
    .attr_reg (attr_reg),
    .attr     (seg_attr),
    .hit      (seg_hit)
  );

  steer_route #(
    .OUTSIDE_TO_DRAM (OUTSIDE_TO_DRAM)
  ) i_route (
    .clk          (clk),
    .rst          (rst),
    .req_valid    (req_valid),
    .req_is_write (req_is_write),
    .hit          (seg_hit),
    .attr         (seg_attr),
    .dec          (dec)
  );

  assign cfg_rdata     = attr_reg;
  assign rsp_valid     = dec.valid;
  assign rsp_to_dram   = dec.target;
  assign rsp_in_window = dec.in_window;
endmodule

// File: tb/test_shadow_steer.sv
`timescale 1ns/1ps
module test_shadow_steer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [19:0] req_addr = '0;
  logic        req_is_write = 1'b0;
  logic        rsp_valid, rsp_to_dram, rsp_in_window;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  shadow_steer i_shadow_steer (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .req_valid(req_valid), .req_addr(req_addr),
    .req_is_write(req_is_write), .rsp_valid(rsp_valid), .rsp_to_dram(rsp_to_dram),
    .rsp_in_window(rsp_in_window));

  // {cfg word, address, is_write, expected to_dram, expected in_window}
  localparam int NVEC = 21;
  localparam logic [54:0] VEC [NVEC] = '{
    {32'h00321032, 20'hD8000, 1'b0, 1'b0, 1'b1}, // R7 seg0=10 read
    {32'h00321032, 20'hDBFFF, 1'b1, 1'b1, 1'b1}, // R7 seg0=10 write, top of segment
    {32'h00321032, 20'hDC000, 1'b0, 1'b1, 1'b1}, // R8 seg1=11 read
    {32'h00321032, 20'hDFFFF, 1'b1, 1'b1, 1'b1}, // R8 seg1 write
    {32'h00321032, 20'hE0000, 1'b0, 1'b0, 1'b1}, // R5 seg2=00 read
    {32'h00321032, 20'hE3FFF, 1'b1, 1'b0, 1'b1}, // R5 seg2 write
    {32'h00321032, 20'hE4000, 1'b0, 1'b1, 1'b1}, // R6 seg3=01 read
    {32'h00321032, 20'hE7FFF, 1'b1, 1'b0, 1'b1}, // R6 seg3 write
    {32'h00321032, 20'hE8000, 1'b1, 1'b1, 1'b1}, // R4 seg4=10 write
    {32'h00321032, 20'hEC000, 1'b0, 1'b1, 1'b1}, // R4 seg5=11 read
    {32'h00321032, 20'hD7FFF, 1'b0, 1'b0, 1'b0}, // R9 just below window
    {32'h00321032, 20'hF0000, 1'b1, 1'b0, 1'b0}, // R9 just above window
    {32'h00123012, 20'hD9234, 1'b1, 1'b1, 1'b1}, // R4 offset bits ignored
    {32'h00123012, 20'hDE000, 1'b0, 1'b1, 1'b1}, // R6 seg1=01 read
    {32'h00123012, 20'hE5555, 1'b1, 1'b1, 1'b1}, // R8 seg3=11 write
    {32'h00123012, 20'hEFFFF, 1'b0, 1'b1, 1'b1}, // R6 seg5=01 read
    {32'h00123012, 20'hEFFFF, 1'b1, 1'b0, 1'b1}, // R6 seg5=01 write
    {32'h00123012, 20'hEAAAA, 1'b0, 1'b0, 1'b1}, // R7 seg4=10 read
    {32'hFFFFCCCD, 20'hD8000, 1'b0, 1'b1, 1'b1}, // R2 reserved ones dropped, seg0=01
    {32'hFFFFCCCD, 20'hED000, 1'b1, 1'b1, 1'b1}, // R2 seg5=11
    {32'hFFFFCCCD, 20'hE1000, 1'b0, 1'b0, 1'b1}  // R2 seg2=00
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = be; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0; cfg_be = '0;
  endtask

  task automatic request(input logic [19:0] a, input logic w);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_is_write = w;
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 register after reset", cfg_rdata, 32'h0);
    chk("R10 no strobe in reset", {31'b0, rsp_valid}, 32'h0);
    @(negedge clk); rst = 1'b0;

    request(20'hEC000, 1'b0);
    chk("R1 reset routes read to link", {30'b0, rsp_to_dram, rsp_in_window}, 32'h1);
    request(20'hD8000, 1'b1);
    chk("R1 reset routes write to link", {30'b0, rsp_to_dram, rsp_in_window}, 32'h1);

    for (int i = 0; i < NVEC; i++) begin
      cfg_write(VEC[i][54:23], 4'hF);
      request(VEC[i][22:3], VEC[i][2]);
      chk($sformatf("R4 vector %0d valid", i), {31'b0, rsp_valid}, 32'h1);
      chk($sformatf("R5 vector %0d route", i), {30'b0, rsp_to_dram, rsp_in_window},
          {30'b0, VEC[i][1:0]});
    end

    cfg_write(32'hFFFFFFFF, 4'hF);
    chk("R2 reserved bits read zero", cfg_rdata, 32'h00333333);
    request(20'h00000, 1'b0);
    chk("R9 low outside default", {30'b0, rsp_to_dram, rsp_in_window}, 32'h0);
    request(20'hD4000, 1'b1);
    chk("R9 below window default", {30'b0, rsp_to_dram, rsp_in_window}, 32'h0);
    request(20'hFFFFF, 1'b1);
    chk("R9 top outside default", {30'b0, rsp_to_dram, rsp_in_window}, 32'h0);
    @(posedge clk); #1;
    chk("R10 no strobe when idle", {31'b0, rsp_valid}, 32'h0);
    chk("R10 fields hold when idle", {30'b0, rsp_to_dram, rsp_in_window}, 32'h0);

    cfg_write(32'h00000000, 4'b0101);
    chk("R3 masked byte write", cfg_rdata, 32'h00003300);
    request(20'hE0000, 1'b1);
    chk("R3 kept byte still routes", {30'b0, rsp_to_dram, rsp_in_window}, 32'h3);
    request(20'hD8000, 1'b0);
    chk("R3 cleared byte routes to link", {30'b0, rsp_to_dram, rsp_in_window}, 32'h1);
    cfg_write(32'hFFFFFFFF, 4'b0000);
    chk("R3 no enables no change", cfg_rdata, 32'h00003300);

    // R11: write and request in the same cycle
    @(negedge clk);
    cfg_wr = 1'b1; cfg_be = 4'hF; cfg_wdata = 32'h00000003;
    req_valid = 1'b1; req_addr = 20'hD8000; req_is_write = 1'b0;
    @(posedge clk); #1;
    cfg_wr = 1'b0; req_valid = 1'b0;
    chk("R11 same-cycle write not used", {30'b0, rsp_to_dram, rsp_in_window}, 32'h1);
    request(20'hD8000, 1'b0);
    chk("R11 write used afterwards", {30'b0, rsp_to_dram, rsp_in_window}, 32'h3);

    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    chk("R1 register cleared by reset", cfg_rdata, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule